// File: doc/BRIEF.md
# Oversampled Right-Justified Stereo Output Serializer

This block sits at the output of an oversampling interpolation filter and feeds a stereo DAC. It takes one parallel left sample and one parallel right sample for each oversampled word period. From the system clock it generates an output bit clock, an output word clock and two serial data lines, one per channel, which run side by side. Each word is sent MSB first and right-justified, so its LSB falls in the last bit slot of the word period. Any slots ahead of the MSB carry zeros.

The word period holds 32 bit slots when the system clock belongs to the 256/512 ratio class and 24 slots when it belongs to the 384/768 class. In four-times oversampling the word rate halves, so the word period doubles to 64 or 48 slots. The output word length can be set to 16, 18, 20 or 24 bits. A shorter word keeps the top bits of the 24-bit sample. After every reset the outputs stay in a fixed quiet state for a programmable hold time before the first word is sent.

Top module: `ovs_rj_serializer`

## Requirements
- R1: The word period is S bit slots. S is 24 when `cfg_wide`=0 and 32 when `cfg_wide`=1, and S doubles when `cfg_x4`=1. Consecutive `take` pulses are therefore 2·S system clocks apart.
- R2: `bck` runs at half the system clock rate. Each bit slot is one system clock with `bck` low followed by one system clock with `bck` high.
- R3: `wck` is high during slots 0 to S/2−1 of each word period and low during the other slots.
- R4: For word-length code `cfg_wlen` 00=16, 01=18, 10=20, 11=24 bits (N bits), slots 0 to S−N−1 carry 0. Slots S−N to S−1 carry bits 23 down to 24−N of the sample, MSB first.
- R5: `wck`, `dol` and `dor` change only on a system clock edge where `bck` falls or stays low.
- R6: From reset release, `bck`, `dol` and `dor` stay 0 and `wck` stays 1 for HOLD_CYCLES (1024) system clocks. The first `take` pulse is high in the cycle that follows HOLD_CYCLES−1 edges after release.
- R7: `take` is high for exactly one system clock per word period. The samples and the configuration inputs are captured at the edge that ends that cycle. Changes to the configuration inputs at any other time do not affect the word in flight.
- R8: `dol` carries only the left sample and `dor` carries only the right sample, each serialized on its own.
- R9: Asserting `rst` while words are being sent forces the quiet state at once. Releasing it starts a new full hold period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wlen | input | 2 | Output word length code |
| cfg_wide | input | 1 | Ratio class: 1 gives 32-slot words, 0 gives 24-slot words |
| cfg_x4 | input | 1 | Four-times oversampling; doubles the slots per word |
| left_in | input | SAMPLE_W | Left sample, two's complement |
| right_in | input | SAMPLE_W | Right sample, two's complement |
| take | output | 1 | Samples captured at the end of this cycle |
| bck | output | 1 | Output bit clock |
| wck | output | 1 | Output word clock |
| dol | output | 1 | Left serial data |
| dor | output | 1 | Right serial data |

## Verification
Errors in the slot counter or in the per-word slot count change the spacing of `take` pulses and shift where `wck` falls. These errors appear within the first word period after the configuration changes. Errors in the latched word length or in the sample register show up as a wrong bit in some slot of the very next word, because the bench compares every slot of every word against a bit computed from the requirement. A hold counter with the wrong count moves the first `take` away from the expected cycle, which the bench checks cycle by cycle during the quiet window.

// File: rtl/ovs_rj_pkg.sv
package ovs_rj_pkg;

    typedef enum logic [1:0] {
        WL16 = 2'b00,
        WL18 = 2'b01,
        WL20 = 2'b10,
        WL24 = 2'b11
    } wlen_e;

    typedef struct packed {
        wlen_e wl;
        logic  wide;
        logic  x4;
    } ser_cfg_t;

    function automatic int wl_bits(wlen_e wl);
        case (wl)
            WL16:    return 16;
            WL18:    return 18;
            WL20:    return 20;
            default: return 24;
        endcase
    endfunction

    function automatic int slot_count(logic wide, logic x4, int narrow, int widen);
        int base;
        base = wide ? widen : narrow;
        return x4 ? 2 * base : base;
    endfunction

endpackage

// File: rtl/ovs_rj_hold.sv
module ovs_rj_hold #(
    parameter int HOLD_CYCLES = 1024
) (
    input  logic clk,
    input  logic rst,
    output logic start
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);

    logic [HW-1:0] cnt;
    logic          done;

    assign start = !done && (cnt == HW'(HOLD_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (start) done <= 1'b1;
            else       cnt  <= cnt + HW'(1);
        end
    end
endmodule

// File: rtl/ovs_rj_timing.sv
module ovs_rj_timing import ovs_rj_pkg::*; #(
    parameter int SLOTS_NARROW = 24,
    parameter int SLOTS_WIDE   = 32,
    parameter int CNT_W        = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  ser_cfg_t         cfg_in,
    output logic             advance,
    output logic             load,
    output logic [CNT_W-1:0] slot_nxt,
    output logic [CNT_W-1:0] slots_nxt,
    output logic [CNT_W-1:0] nbits_nxt,
    output logic             bck,
    output logic             wck
);
    logic             run;
    logic             phase;
    logic             wrap;
    logic [CNT_W-1:0] slot;
    logic [CNT_W-1:0] slots_cur;
    logic [CNT_W-1:0] nbits_cur;

    always_comb begin
        advance   = start | (run & phase);
        wrap      = start | (slot == slots_cur - CNT_W'(1));
        load      = advance & wrap;
        slot_nxt  = wrap ? '0 : slot + CNT_W'(1);
        slots_nxt = load ? CNT_W'(slot_count(cfg_in.wide, cfg_in.x4, SLOTS_NARROW, SLOTS_WIDE))
                         : slots_cur;
        nbits_nxt = load ? CNT_W'(wl_bits(cfg_in.wl)) : nbits_cur;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run       <= 1'b0;
            phase     <= 1'b0;
            slot      <= '0;
            slots_cur <= CNT_W'(SLOTS_NARROW);
            nbits_cur <= CNT_W'(16);
            bck       <= 1'b0;
            wck       <= 1'b1;
        end else begin
            if (start) run <= 1'b1;
            if (advance) begin
                phase     <= 1'b0;
                bck       <= 1'b0;
                slot      <= slot_nxt;
                slots_cur <= slots_nxt;
                nbits_cur <= nbits_nxt;
                wck       <= slot_nxt < (slots_nxt >> 1);
            end else if (run) begin
                phase <= 1'b1;
                bck   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ovs_rj_lane.sv
module ovs_rj_lane #(
    parameter int SAMPLE_W = 24,
    parameter int CNT_W    = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic                load,
    input  logic [CNT_W-1:0]    slot_nxt,
    input  logic [CNT_W-1:0]    slots_nxt,
    input  logic [CNT_W-1:0]    nbits_nxt,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic                bit_q
);
    localparam int IDX_W = $clog2(SAMPLE_W);

    logic [SAMPLE_W-1:0] held;
    logic [SAMPLE_W-1:0] src;
    logic [CNT_W-1:0]    pad;
    logic [CNT_W-1:0]    off;
    logic [IDX_W-1:0]    idx;
    logic                bit_nxt;

    always_comb begin
        src     = load ? sample_in : held;
        pad     = slots_nxt - nbits_nxt;
        off     = slot_nxt - pad;
        idx     = IDX_W'(SAMPLE_W - 1) - IDX_W'(off);
        bit_nxt = (slot_nxt < pad) ? 1'b0 : src[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            bit_q <= 1'b0;
        end else if (step) begin
            if (load) held <= sample_in;
            bit_q <= bit_nxt;
        end
    end
endmodule

// File: rtl/ovs_rj_serializer.sv
module ovs_rj_serializer import ovs_rj_pkg::*; #(
    parameter int SAMPLE_W     = 24,
    parameter int SLOTS_NARROW = 24,
    parameter int SLOTS_WIDE   = 32,
    parameter int HOLD_CYCLES  = 1024
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_wlen,
    input  logic                cfg_wide,
    input  logic                cfg_x4,
    input  logic [SAMPLE_W-1:0] left_in,
    input  logic [SAMPLE_W-1:0] right_in,
    output logic                take,
    output logic                bck,
    output logic                wck,
    output logic                dol,
    output logic                dor
);
    localparam int CNT_W = $clog2(2 * SLOTS_WIDE + 1);

    ser_cfg_t            cfg;
    logic                start;
    logic                advance;
    logic                load;
    logic [CNT_W-1:0]    slot_nxt;
    logic [CNT_W-1:0]    slots_nxt;
    logic [CNT_W-1:0]    nbits_nxt;
    logic [SAMPLE_W-1:0] samp [2];
    logic                lane_q [2];

    assign cfg     = '{wl: wlen_e'(cfg_wlen), wide: cfg_wide, x4: cfg_x4};
    assign samp[0] = left_in;
    assign samp[1] = right_in;

    ovs_rj_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .start (start)
    );

    ovs_rj_timing #(
        .SLOTS_NARROW (SLOTS_NARROW),
        .SLOTS_WIDE   (SLOTS_WIDE),
        .CNT_W        (CNT_W)
    ) u_timing (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_in    (cfg),
        .advance   (advance),
        .load      (load),
        .slot_nxt  (slot_nxt),
        .slots_nxt (slots_nxt),
        .nbits_nxt (nbits_nxt),
        .bck       (bck),
        .wck       (wck)
    );

    for (genvar ch = 0; ch < 2; ch++) begin : g_lane
        ovs_rj_lane #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .step      (advance),
            .load      (load),
            .slot_nxt  (slot_nxt),
            .slots_nxt (slots_nxt),
            .nbits_nxt (nbits_nxt),
            .sample_in (samp[ch]),
            .bit_q     (lane_q[ch])
        );
    end

    assign take = load;
    assign dol  = lane_q[0];
    assign dor  = lane_q[1];
endmodule

// File: rtl/ovs_rj_checker.sv
module ovs_rj_checker #(
    parameter int HOLD_CYCLES = 1024
) (
    input logic clk,
    input logic rst,
    input logic take,
    input logic bck,
    input logic wck,
    input logic dol,
    input logic dor
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);

    logic [HW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                             since_rst <= '0;
        else if (since_rst != HW'(HOLD_CYCLES)) since_rst <= since_rst + HW'(1);
    end

    a_r6_quiet_hold: assert property (@(posedge clk) disable iff (rst)
        (since_rst < HW'(HOLD_CYCLES)) |-> (!bck && wck && !dol && !dor));

    a_r5_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable({wck, dol, dor}) |-> !bck);

    a_r2_bck_one_high: assert property (@(posedge clk) disable iff (rst)
        $rose(bck) |=> $fell(bck));

    a_r7_take_single: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    a_r3_word_opens_high: assert property (@(posedge clk) disable iff (rst)
        take |=> (wck && !bck));
endmodule

bind ovs_rj_serializer ovs_rj_checker #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .take (take),
    .bck  (bck),
    .wck  (wck),
    .dol  (dol),
    .dor  (dor)
);

// File: tb/ovs_rj_serializer_tb.sv
module ovs_rj_serializer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_wlen = 2'b00;
    logic        cfg_wide = 1'b0;
    logic        cfg_x4 = 1'b0;
    logic [23:0] left_in = '0;
    logic [23:0] right_in = '0;
    logic        take, bck, wck, dol, dor;

    int n_vec  = 0;
    int n_fail = 0;
    int word_no = 0;
    int unsigned seed_init;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovs_rj_serializer u_dut (
        .clk(clk), .rst(rst), .cfg_wlen(cfg_wlen), .cfg_wide(cfg_wide),
        .cfg_x4(cfg_x4), .left_in(left_in), .right_in(right_in),
        .take(take), .bck(bck), .wck(wck), .dol(dol), .dor(dor)
    );

    function automatic int exp_slots(logic wide, logic x4);
        return (wide ? 32 : 24) * (x4 ? 2 : 1);
    endfunction

    function automatic int exp_nbits(logic [1:0] wl);
        case (wl)
            2'b00:   return 16;
            2'b01:   return 18;
            2'b10:   return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic exp_bit(logic [23:0] s, int slot, int slots, int nb);
        if (slot < slots - nb) return 1'b0;
        return s[23 - (slot - (slots - nb))];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h (word %0d)", req, act, exp, word_no);
        end
    endtask

    task automatic present_next();
        if (word_no < 12) begin
            cfg_wlen = 2'(word_no % 4);
            {cfg_wide, cfg_x4} = 2'(word_no / 4);
            left_in  = (word_no % 2 == 1) ? 24'h7FFFFF : 24'h800000;
            right_in = 24'hA5C3F1 ^ 24'(word_no);
        end else begin
            cfg_wlen = 2'($urandom_range(0, 3));
            cfg_wide = 1'($urandom_range(0, 1));
            cfg_x4   = 1'($urandom_range(0, 1));
            left_in  = 24'($urandom);
            right_in = 24'($urandom);
        end
    endtask

    task automatic check_quiet(string req);
        check(req, {28'd0, bck, wck, dol, dor}, {28'd0, 4'b0100});
    endtask

    // Returns at the negedge where the first take is seen.
    task automatic run_from_reset(string req);
        @(negedge clk);
        rst = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check_quiet(req);
            check("R7 take in reset", {31'd0, take}, 32'd0);
        end
        present_next();
        rst = 1'b0;
        check_quiet("R6");
        for (int k = 1; k < HOLD; k++) begin
            @(negedge clk);
            check_quiet("R6 quiet window");
            check("R6 first take timing", {31'd0, take}, {31'd0, k == HOLD - 1});
        end
    endtask

    task automatic run_words(int count);
        for (int w = 0; w < count; w++) begin
            logic [23:0] l, r;
            int slots, nb;
            l = left_in;
            r = right_in;
            slots = exp_slots(cfg_wide, cfg_x4);
            nb = exp_nbits(cfg_wlen);
            @(posedge clk);
            #1;
            word_no++;
            present_next();
            for (int s = 0; s < slots; s++) begin
                @(negedge clk);
                check("R2 bck low", {31'd0, bck}, 32'd0);
                check("R3 wck", {31'd0, wck}, {31'd0, s < slots / 2});
                check("R4 dol", {31'd0, dol}, {31'd0, exp_bit(l, s, slots, nb)});
                check("R8 dor", {31'd0, dor}, {31'd0, exp_bit(r, s, slots, nb)});
                check("R7 take", {31'd0, take}, 32'd0);
                @(negedge clk);
                check("R2 bck high", {31'd0, bck}, 32'd1);
                check("R5 wck held", {31'd0, wck}, {31'd0, s < slots / 2});
                check("R5 dol held", {31'd0, dol}, {31'd0, exp_bit(l, s, slots, nb)});
                check("R5 dor held", {31'd0, dor}, {31'd0, exp_bit(r, s, slots, nb)});
                check("R1 take period", {31'd0, take}, {31'd0, s == slots - 1});
            end
        end
    endtask

    initial begin
        seed_init = $urandom(32'd20240611);
        run_from_reset("R6 reset state");
        run_words(170);
        for (int k = 0; k < 7; k++) @(negedge clk);
        run_from_reset("R9 reset mid word");
        run_words(30);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule